// File: doc/BRIEF.md
# Serial Interrupt Stop-Frame Mode Tracker

This block observes a shared serial interrupt line, sampled once per bus clock, and identifies the stop frame that the host places at the end of each serial interrupt cycle. It arms only after a separate input reports that the cycle's data and interrupt frames are over. Once armed, it counts how many consecutive clocks the host holds the line low. From that count it decides whether the next serial interrupt cycle runs in quiet mode or in continuous mode.

A low time of two clocks selects quiet mode. A low time of three clocks selects continuous mode. Any other low time is reported as a malformed stop, and the mode does not change. The block never drives the line. It has no output to the line and only reads it, so the host stays the only agent that can end a cycle. Logic that owns the interrupt slots and the start frame reads `next_mode` to choose its behaviour for the following cycle.

Top module: `sirq_stop_tracker`

## Requirements
- R1: Low samples on `sirq_in` are ignored until `frames_done` has been sampled high at a clock edge. Such samples change neither `next_mode` nor the pulses.
- R2: An armed tracker evaluates exactly one stop frame. After that evaluation, later low pulses are ignored until `frames_done` is sampled high again.
- R3: A low width of exactly 2 sets `next_mode` to 0 (quiet) and raises `stop_seen`. The outputs update on the clock edge at which the first high sample follows the low run.
- R4: A low width of exactly 3 sets `next_mode` to 1 (continuous) and raises `stop_seen`, with the same timing as R3.
- R5: Any other low width (1, or 4 and more) raises `stop_bad` for one cycle, leaves `next_mode` unchanged and does not raise `stop_seen`.
- R6: The width is the number of consecutive low samples taken while armed, ending at the first high sample. The count saturates at 2^CNT_W-1, so a very long low never wraps back to a valid width.
- R7: While `rst_n` is low at a clock edge, `next_mode` becomes 1 (continuous), both pulses become 0, and any measurement in progress is discarded.
- R8: `stop_seen` is high for exactly one clock cycle per valid stop frame. The line is low for the sample just before that cycle's triggering high sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sirq_in | input | 1 | Sampled level of the serial interrupt line |
| frames_done | input | 1 | High when the current cycle's data/interrupt frames have finished |
| next_mode | output | 1 | Mode of the next cycle: 1 continuous, 0 quiet |
| stop_seen | output | 1 | One-cycle pulse after a valid stop frame |
| stop_bad | output | 1 | One-cycle pulse after a stop frame of invalid width |

## Verification
The hardest case to reach from the ports is a low pulse that falls outside the armed window. Examples are a pulse just after a stop frame has been evaluated, or a measurement that a reset cuts short. In these cases the block must show no change at all. The stimulus first forces the mode to quiet with a two-clock stop. It then sends two-clock and three-clock lows without re-arming, and also resets during an armed low run. Any false evaluation therefore appears as a visible mode flip or a stray pulse. The saturation corner is reached by holding the line low well past the counter's range, then checking that only the malformed flag fires.

// File: rtl/sirq_stop_pkg.sv
// Package: shared types for the serial interrupt stop-frame tracker.
// Assumes: nothing beyond standard SystemVerilog enum encoding.
package sirq_stop_pkg;

    // Protocol mode for the following serial interrupt cycle.
    typedef enum logic {
        MODE_QUIET = 1'b0,
        MODE_CONT  = 1'b1
    } sirq_mode_e;

    // Arming state of the stop-frame observer.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_LOW   = 2'd2
    } stop_state_e;

endpackage

// File: rtl/sirq_arm_ctrl.sv
// Module: sirq_arm_ctrl
// Tracks whether a stop frame may be measured. It arms when the frames of a
// cycle are reported complete, enters the low phase on the first low sample,
// and finishes on the first high sample after it. It then disarms.
// Assumes: line_in is already synchronous to clk; frames_done may be a pulse
// or a level, and only its value in the idle state matters.
module sirq_arm_ctrl
    import sirq_stop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic frames_done,
    output logic cnt_en,
    output logic cnt_clr,
    output logic meas_done
);

    stop_state_e state_q;
    stop_state_e state_d;

    // Next-state selection for the arming sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (frames_done) state_d = ST_ARMED;
            ST_ARMED: if (!line_in)    state_d = ST_LOW;
            ST_LOW:   if (line_in)     state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Counter controls and completion strobe derived from state and line.
    always_comb begin
        cnt_en    = (state_q != ST_IDLE) && !line_in;
        cnt_clr   = (state_q == ST_IDLE);
        meas_done = (state_q == ST_LOW) && line_in;
    end

    // R1: idle with no completion report stays idle.
    p_arm_needs_frames_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !frames_done) |=> (state_q == ST_IDLE));

    // R2: every completed measurement returns to idle.
    p_single_eval_r2: assert property (@(posedge clk) disable iff (!rst_n)
        meas_done |=> (state_q == ST_IDLE));

    // R6: the low phase is only entered from a low sample.
    p_low_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && line_in) |=> (state_q == ST_ARMED));

endmodule

// File: rtl/sirq_low_meter.sv
// Module: sirq_low_meter
// Counts consecutive low samples while enabled. The count saturates at its
// maximum so that an overlong low can never alias to a short width.
// Assumes: cnt_clr and cnt_en are never requested at once by the controller.
module sirq_low_meter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             cnt_clr,
    output logic [CNT_W-1:0] width
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] width_q;

    // Saturating width counter with clear.
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_clr)                  width_q <= '0;
        else if (cnt_en && width_q != CNT_MAX)  width_q <= width_q + 1'b1;
    end

    assign width = width_q;

    // R6: a saturated count never wraps to a small value unless cleared.
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (width_q == CNT_MAX && !cnt_clr) |=> (width_q == CNT_MAX));

    // R6: without enable or clear the count holds.
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !cnt_clr) |=> $stable(width_q));

endmodule

// File: rtl/sirq_mode_decode.sv
// Module: sirq_mode_decode
// Turns a finished low width into the next-cycle mode and the outcome pulses.
// Assumes: meas_done is a one-cycle strobe that arrives while width still
// holds the completed count.
module sirq_mode_decode
    import sirq_stop_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int QUIET_LOW = 2,
    parameter int CONT_LOW  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_done,
    input  logic [CNT_W-1:0] width,
    output sirq_mode_e       mode,
    output logic             seen,
    output logic             bad
);

    localparam logic [CNT_W-1:0] QUIET_CODE = QUIET_LOW[CNT_W-1:0];
    localparam logic [CNT_W-1:0] CONT_CODE  = CONT_LOW[CNT_W-1:0];

    sirq_mode_e mode_q;
    logic       seen_q;
    logic       bad_q;

    // Mode register and single-cycle outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_CONT;
            seen_q <= 1'b0;
            bad_q  <= 1'b0;
        end else begin
            seen_q <= 1'b0;
            bad_q  <= 1'b0;
            if (meas_done) begin
                if (width == QUIET_CODE) begin
                    mode_q <= MODE_QUIET;
                    seen_q <= 1'b1;
                end else if (width == CONT_CODE) begin
                    mode_q <= MODE_CONT;
                    seen_q <= 1'b1;
                end else begin
                    bad_q  <= 1'b1;
                end
            end
        end
    end

    assign mode = mode_q;
    assign seen = seen_q;
    assign bad  = bad_q;

    // R3: two-clock low selects quiet.
    p_quiet_on_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_done && width == QUIET_CODE) |=> (mode_q == MODE_QUIET && seen_q));

    // R4: three-clock low selects continuous.
    p_cont_on_three_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_done && width == CONT_CODE) |=> (mode_q == MODE_CONT && seen_q));

    // R5: other widths flag and keep the mode.
    p_bad_keeps_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_done && width != QUIET_CODE && width != CONT_CODE)
            |=> (bad_q && !seen_q && $stable(mode_q)));

    // R7: first cycle after reset shows continuous with no pulses.
    p_reset_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mode_q == MODE_CONT && !seen_q && !bad_q));

endmodule

// File: rtl/sirq_stop_tracker.sv
// Module: sirq_stop_tracker (top)
// Watches the serial interrupt line after the data frames of a cycle and
// decodes the host's stop-frame low width into the next cycle's mode.
// Assumes: sirq_in is already synchronised and sampled on clk; the block
// never drives the line.
module sirq_stop_tracker
    import sirq_stop_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int QUIET_LOW = 2,
    parameter int CONT_LOW  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sirq_in,
    input  logic frames_done,
    output logic next_mode,
    output logic stop_seen,
    output logic stop_bad
);

    logic             cnt_en;
    logic             cnt_clr;
    logic             meas_done;
    logic [CNT_W-1:0] width;
    sirq_mode_e       mode;

    sirq_arm_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_in     (sirq_in),
        .frames_done (frames_done),
        .cnt_en      (cnt_en),
        .cnt_clr     (cnt_clr),
        .meas_done   (meas_done)
    );

    sirq_low_meter #(.CNT_W(CNT_W)) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .cnt_clr (cnt_clr),
        .width   (width)
    );

    sirq_mode_decode #(
        .CNT_W     (CNT_W),
        .QUIET_LOW (QUIET_LOW),
        .CONT_LOW  (CONT_LOW)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .meas_done (meas_done),
        .width     (width),
        .mode      (mode),
        .seen      (stop_seen),
        .bad       (stop_bad)
    );

    assign next_mode = (mode == MODE_CONT);

    // R8: a valid stop pulse follows a high sample preceded by a low one.
    p_seen_after_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_seen && $past(rst_n)) |-> ($past(sirq_in) && !$past(sirq_in, 2)));

    // R8: the valid pulse lasts a single cycle.
    p_seen_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> !stop_seen);

    // R5: valid and malformed outcomes never coincide.
    p_outcome_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(stop_seen && stop_bad));

endmodule

// File: tb/sirq_stop_tracker_tb_top.sv
module sirq_stop_tracker_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sirq_in = 1'b1;
    logic frames_done = 1'b0;
    logic next_mode;
    logic stop_seen;
    logic stop_bad;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sirq_stop_tracker dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sirq_in     (sirq_in),
        .frames_done (frames_done),
        .next_mode   (next_mode),
        .stop_seen   (stop_seen),
        .stop_bad    (stop_bad)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sirq_in = 1'b1; frames_done = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Arm, hold low for w clocks, release; checks outputs after the high edge.
    task automatic send_stop(input int w, input string req,
                             input int exp_mode, input int exp_seen, input int exp_bad);
        @(negedge clk);
        frames_done = 1'b1;
        @(negedge clk);
        frames_done = 1'b0;
        sirq_in = 1'b0;
        repeat (w) @(negedge clk);
        sirq_in = 1'b1;
        chk({req, " no early pulse"}, stop_seen | stop_bad, 0);
        @(negedge clk);
        chk({req, " mode"}, next_mode, exp_mode);
        chk({req, " seen"}, stop_seen, exp_seen);
        chk({req, " bad"}, stop_bad, exp_bad);
        @(negedge clk);
        chk({req, " pulse cleared"}, stop_seen | stop_bad, 0);
    endtask

    // Low pulse with no arming; nothing may change.
    task automatic stray_low(input int w, input string req, input int exp_mode);
        @(negedge clk);
        sirq_in = 1'b0;
        repeat (w) @(negedge clk);
        sirq_in = 1'b1;
        repeat (2) begin
            @(negedge clk);
            chk({req, " stray pulse"}, stop_seen | stop_bad, 0);
            chk({req, " stray mode"}, next_mode, exp_mode);
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        chk("R7 reset mode", next_mode, 1);
        chk("R7 reset seen", stop_seen, 0);
        chk("R7 reset bad", stop_bad, 0);
    endtask

    task automatic t_unarmed();
        stray_low(2, "R1", 1);
        stray_low(3, "R1", 1);
    endtask

    task automatic t_valid_widths();
        send_stop(2, "R3 R8 width2", 0, 1, 0);
        send_stop(3, "R4 width3", 1, 1, 0);
        send_stop(2, "R3 width2 again", 0, 1, 0);
    endtask

    task automatic t_bad_widths();
        send_stop(1, "R5 width1", 0, 0, 1);
        send_stop(4, "R5 width4", 0, 0, 1);
        send_stop(20, "R6 saturated width20", 0, 0, 1);
        send_stop(18, "R6 width18 no wrap to 2", 0, 0, 1);
    endtask

    task automatic t_single_eval();
        send_stop(2, "R2 setup quiet", 0, 1, 0);
        stray_low(3, "R2 after eval", 0);
        send_stop(3, "R2 rearmed", 1, 1, 0);
    endtask

    task automatic t_reset_mid();
        send_stop(2, "R7 setup quiet", 0, 1, 0);
        @(negedge clk);
        frames_done = 1'b1;
        @(negedge clk);
        frames_done = 1'b0;
        sirq_in = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R7 mid reset mode", next_mode, 1);
        @(negedge clk);
        @(negedge clk);
        sirq_in = 1'b1;
        @(negedge clk);
        chk("R7 discarded seen", stop_seen, 0);
        chk("R7 discarded bad", stop_bad, 0);
        chk("R7 discarded mode", next_mode, 1);
    endtask

    initial begin
        t_reset_state();
        t_unarmed();
        t_valid_widths();
        t_bad_widths();
        t_single_eval();
        t_reset_mid();
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule